// File: doc/BRIEF.md
# Destination-Indexed Load Miss Tracker

This block keeps track of data-cache load misses that are still waiting on memory. It has one slot for each physical destination register, not one slot for each missing line. Any number of misses, to any mix of lines, can therefore be outstanding at the same time, up to one per register. Each allocation records three things: the destination register, the missing line address, and which 64-bit word of the 32-byte line the load wants. When memory hands back a line, every slot waiting on that line delivers its word to its register in the same cycle. The line is then passed on as a cache fill.

Instructions can be removed from the pipeline while their miss is still outstanding. When that happens, the scheduler sets the destination's bit in a squash mask. The slot stays busy until its line comes back. It then writes nothing, and it does not by itself cause a cache fill.

A second miss to a line that is already on its way from memory does not start another fetch. It only adds a slot. The memory behind the block answers every fetch after a fixed delay.

Top module: `imshr_file`

## Requirements
- R1: After reset every slot is empty: `rf_we` and `fill_valid` are low, and a line return with no prior allocation writes no register and causes no fill.
- R2: An allocation on port p with no line already outstanding raises `fetch_valid[p]` combinationally in the same cycle. Several ports may start fetches in one cycle.
- R3: An allocation raises no fetch if either of two things holds. The first: a busy slot, cancelled or not, already holds the same line and that line is not being returned in this cycle. The second: a lower-numbered port allocates the same line in the same cycle.
- R4: A line return is sampled at a clock edge. Right after that edge, for one cycle, every busy, uncancelled slot holding that line has its `rf_we` bit high. Its `rf_wdata` entry is word k of `ret_data`, that is bits [64k+63:64k], where k is the 2-bit word select (word 0 is the least significant).
- R5: A return clears every busy slot holding that line, cancelled or not. A later return of the same line writes nothing.
- R6: A set `squash_mask` bit cancels a busy slot. The cancelled slot writes nothing when its line returns, and a squash in the same cycle as the return also suppresses the write.
- R7: `fill_valid` is high in the cycle after a return exactly when at least one register is written. `fill_line` and `fill_data` then carry the returned line address and data. Otherwise the returned line is dropped.
- R8: An allocation overwrites its destination's slot, leaving it busy and uncancelled. If two ports name the same destination in one cycle, the higher-numbered port wins. An allocation beats a squash of the same destination in the same cycle.
- R9: All slots can be busy at once on distinct lines, and each one is written when its own line returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | ALLOC_N | Allocation request per port |
| alloc_dest | input | ALLOC_N x DEST_W | Destination register per port |
| alloc_line | input | ALLOC_N x LINE_AW | Missing line address per port |
| alloc_word | input | ALLOC_N x 2 | Word select within the line |
| squash_mask | input | DEST_N | Cancel the slot of each set destination |
| ret_valid | input | 1 | A line is returned from memory |
| ret_line | input | LINE_AW | Address of the returned line |
| ret_data | input | 256 | Returned line, word 0 in the low bits |
| fetch_valid | output | ALLOC_N | Start a memory fetch for alloc_line of that port |
| rf_we | output | DEST_N | Register write enables |
| rf_wdata | output | DEST_N x 64 | Register write data |
| fill_valid | output | 1 | Cache line fill |
| fill_line | output | LINE_AW | Fill line address |
| fill_data | output | 256 | Fill line data |

## Verification
Each kind of wrong slot state shows up at the ports in a specific way:

- A slot that holds the wrong line or word puts wrong data or a missing write enable on the register ports, one cycle after its line comes back.
- A slot that fails to clear writes a second time when the same line returns again.
- A lost cancel bit writes a register that should have stayed silent, and it can also produce a fill.
- A wrong busy flag is visible even earlier. It changes `fetch_valid` combinationally, in the same cycle as the next allocation to that line.

// File: rtl/imshr_pkg.sv
package imshr_pkg;
    localparam int WORD_W     = 64;
    localparam int LINE_WORDS = 4;
    localparam int OFS_W      = $clog2(LINE_WORDS);
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int LINE_AW    = 12;

    typedef struct packed {
        logic               busy;
        logic               cancel;
        logic [LINE_AW-1:0] line;
        logic [OFS_W-1:0]   word;
    } slot_t;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] d,
                                                    input logic [OFS_W-1:0]  s);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int w = 0; w < LINE_WORDS; w++)
            if (OFS_W'(w) == s) r = d[w*WORD_W +: WORD_W];
        return r;
    endfunction
endpackage

// File: rtl/imshr_slot.sv
module imshr_slot
    import imshr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [LINE_AW-1:0] set_line,
    input  logic [OFS_W-1:0]   set_word,
    input  logic               squash,
    input  logic               ret_valid,
    input  logic [LINE_AW-1:0] ret_line,
    input  logic [LINE_W-1:0]  ret_data,
    output slot_t              state_o,
    output logic               wr_en,
    output logic [WORD_W-1:0]  wr_data
);
    slot_t st;
    logic  hit;

    assign hit     = st.busy && ret_valid && (st.line == ret_line);
    assign wr_en   = hit && !st.cancel && !squash;
    assign wr_data = pick_word(ret_data, st.word);
    assign state_o = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (set_en) begin
            st.busy   <= 1'b1;
            st.cancel <= 1'b0;
            st.line   <= set_line;
            st.word   <= set_word;
        end else if (hit) begin
            st.busy   <= 1'b0;
            st.cancel <= 1'b0;
        end else if (squash && st.busy) begin
            st.cancel <= 1'b1;
        end
    end
endmodule

// File: rtl/imshr_fetch_filter.sv
module imshr_fetch_filter
    import imshr_pkg::*;
#(
    parameter int DEST_N  = 8,
    parameter int ALLOC_N = 2
) (
    input  logic [ALLOC_N-1:0]              alloc_valid,
    input  logic [ALLOC_N-1:0][LINE_AW-1:0] alloc_line,
    input  slot_t [DEST_N-1:0]              slots,
    input  logic                            ret_valid,
    input  logic [LINE_AW-1:0]              ret_line,
    output logic [ALLOC_N-1:0]              fetch_valid
);
    always_comb begin
        for (int p = 0; p < ALLOC_N; p++) begin
            logic in_flight;
            in_flight = 1'b0;
            for (int d = 0; d < DEST_N; d++)
                if (slots[d].busy && slots[d].line == alloc_line[p] &&
                    !(ret_valid && ret_line == alloc_line[p]))
                    in_flight = 1'b1;
            for (int q = 0; q < ALLOC_N; q++)
                if (q < p && alloc_valid[q] && alloc_line[q] == alloc_line[p])
                    in_flight = 1'b1;
            fetch_valid[p] = alloc_valid[p] && !in_flight;
        end
    end
endmodule

// File: rtl/imshr_writeback.sv
module imshr_writeback
    import imshr_pkg::*;
#(
    parameter int DEST_N = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [DEST_N-1:0]               wr_en,
    input  logic [DEST_N-1:0][WORD_W-1:0]   wr_data,
    input  logic [LINE_AW-1:0]              ret_line,
    input  logic [LINE_W-1:0]               ret_data,
    output logic [DEST_N-1:0]               rf_we,
    output logic [DEST_N-1:0][WORD_W-1:0]   rf_wdata,
    output logic                            fill_valid,
    output logic [LINE_AW-1:0]              fill_line,
    output logic [LINE_W-1:0]               fill_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rf_we      <= '0;
            rf_wdata   <= '0;
            fill_valid <= 1'b0;
            fill_line  <= '0;
            fill_data  <= '0;
        end else begin
            rf_we      <= wr_en;
            rf_wdata   <= wr_data;
            fill_valid <= |wr_en;
            fill_line  <= ret_line;
            fill_data  <= ret_data;
        end
    end
endmodule

// File: rtl/imshr_file.sv
module imshr_file
    import imshr_pkg::*;
#(
    parameter int DEST_N  = 8,
    parameter int ALLOC_N = 2,
    localparam int DEST_W = $clog2(DEST_N)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ALLOC_N-1:0]              alloc_valid,
    input  logic [ALLOC_N-1:0][DEST_W-1:0]  alloc_dest,
    input  logic [ALLOC_N-1:0][LINE_AW-1:0] alloc_line,
    input  logic [ALLOC_N-1:0][OFS_W-1:0]   alloc_word,
    input  logic [DEST_N-1:0]               squash_mask,
    input  logic                            ret_valid,
    input  logic [LINE_AW-1:0]              ret_line,
    input  logic [LINE_W-1:0]               ret_data,
    output logic [ALLOC_N-1:0]              fetch_valid,
    output logic [DEST_N-1:0]               rf_we,
    output logic [DEST_N-1:0][WORD_W-1:0]   rf_wdata,
    output logic                            fill_valid,
    output logic [LINE_AW-1:0]              fill_line,
    output logic [LINE_W-1:0]               fill_data
);
    logic [DEST_N-1:0]              set_en;
    logic [DEST_N-1:0][LINE_AW-1:0] set_line;
    logic [DEST_N-1:0][OFS_W-1:0]   set_word;
    slot_t [DEST_N-1:0]             slots;
    logic [DEST_N-1:0]              wr_en;
    logic [DEST_N-1:0][WORD_W-1:0]  wr_data;

    // Allocation decode: the highest port naming a destination wins.
    always_comb begin
        for (int d = 0; d < DEST_N; d++) begin
            set_en[d]   = 1'b0;
            set_line[d] = '0;
            set_word[d] = '0;
            for (int p = 0; p < ALLOC_N; p++) begin
                if (alloc_valid[p] && alloc_dest[p] == DEST_W'(d)) begin
                    set_en[d]   = 1'b1;
                    set_line[d] = alloc_line[p];
                    set_word[d] = alloc_word[p];
                end
            end
        end
    end

    for (genvar g = 0; g < DEST_N; g++) begin : g_slot
        imshr_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .set_en    (set_en[g]),
            .set_line  (set_line[g]),
            .set_word  (set_word[g]),
            .squash    (squash_mask[g]),
            .ret_valid (ret_valid),
            .ret_line  (ret_line),
            .ret_data  (ret_data),
            .state_o   (slots[g]),
            .wr_en     (wr_en[g]),
            .wr_data   (wr_data[g])
        );
    end

    imshr_fetch_filter #(.DEST_N(DEST_N), .ALLOC_N(ALLOC_N)) u_filter (
        .alloc_valid (alloc_valid),
        .alloc_line  (alloc_line),
        .slots       (slots),
        .ret_valid   (ret_valid),
        .ret_line    (ret_line),
        .fetch_valid (fetch_valid)
    );

    imshr_writeback #(.DEST_N(DEST_N)) u_wb (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ret_line   (ret_line),
        .ret_data   (ret_data),
        .rf_we      (rf_we),
        .rf_wdata   (rf_wdata),
        .fill_valid (fill_valid),
        .fill_line  (fill_line),
        .fill_data  (fill_data)
    );
endmodule

// File: rtl/imshr_chk.sv
module imshr_chk
    import imshr_pkg::*;
#(
    parameter int DEST_N  = 8,
    parameter int ALLOC_N = 2,
    localparam int DEST_W = $clog2(DEST_N)
) (
    input logic                            clk,
    input logic                            rst,
    input logic [ALLOC_N-1:0]              alloc_valid,
    input logic [ALLOC_N-1:0][DEST_W-1:0]  alloc_dest,
    input logic [ALLOC_N-1:0][LINE_AW-1:0] alloc_line,
    input logic [ALLOC_N-1:0][OFS_W-1:0]   alloc_word,
    input logic [DEST_N-1:0]               squash_mask,
    input logic                            ret_valid,
    input logic [LINE_AW-1:0]              ret_line,
    input logic [LINE_W-1:0]               ret_data,
    input logic [ALLOC_N-1:0]              fetch_valid,
    input logic [DEST_N-1:0]               rf_we,
    input logic [DEST_N-1:0][WORD_W-1:0]   rf_wdata,
    input logic                            fill_valid,
    input logic [LINE_AW-1:0]              fill_line,
    input logic [LINE_W-1:0]               fill_data
);
    logic twin_fetch;
    always_comb begin
        twin_fetch = 1'b0;
        for (int a = 0; a < ALLOC_N; a++)
            for (int b = 0; b < ALLOC_N; b++)
                if (a < b && fetch_valid[a] && fetch_valid[b] &&
                    alloc_line[a] == alloc_line[b])
                    twin_fetch = 1'b1;
    end

    AST_FETCH_NEEDS_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid & ~alloc_valid) == '0); // R2
    AST_NO_TWIN_FETCH: assert property (@(posedge clk) disable iff (rst)
        !twin_fetch); // R3
    AST_WRITE_NEEDS_RETURN: assert property (@(posedge clk) disable iff (rst)
        (|rf_we) |-> $past(ret_valid)); // R4
    AST_SQUASH_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rf_we & $past(squash_mask)) == '0); // R6
    AST_FILL_LINE_MATCH: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (fill_line == $past(ret_line) && fill_data == $past(ret_data))); // R7
    AST_FILL_HAS_WRITE: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> $countones(rf_we) > 0); // R7
endmodule

bind imshr_file imshr_chk #(.DEST_N(DEST_N), .ALLOC_N(ALLOC_N)) u_chk (.*);

// File: tb/sim_imshr_file.sv
`timescale 1ns/1ps
module sim_imshr_file;
    import imshr_pkg::*;
    localparam int DEST_N  = 8;
    localparam int ALLOC_N = 2;
    localparam int DEST_W  = $clog2(DEST_N);
    localparam int LAT     = 16;

    logic                            clk = 1'b0;
    logic                            rst;
    logic [ALLOC_N-1:0]              alloc_valid;
    logic [ALLOC_N-1:0][DEST_W-1:0]  alloc_dest;
    logic [ALLOC_N-1:0][LINE_AW-1:0] alloc_line;
    logic [ALLOC_N-1:0][OFS_W-1:0]   alloc_word;
    logic [DEST_N-1:0]               squash_mask;
    logic                            ret_valid;
    logic [LINE_AW-1:0]              ret_line;
    logic [LINE_W-1:0]               ret_data;
    logic [ALLOC_N-1:0]              fetch_valid;
    logic [DEST_N-1:0]               rf_we;
    logic [DEST_N-1:0][WORD_W-1:0]   rf_wdata;
    logic                            fill_valid;
    logic [LINE_AW-1:0]              fill_line;
    logic [LINE_W-1:0]               fill_data;

    always #2 clk = ~clk;

    imshr_file #(.DEST_N(DEST_N), .ALLOC_N(ALLOC_N)) u0 (.*);

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;

    bit               m_busy   [DEST_N];
    bit               m_cancel [DEST_N];
    bit [LINE_AW-1:0] m_line   [DEST_N];
    bit [OFS_W-1:0]   m_word   [DEST_N];

    bit [LINE_AW-1:0] pl_line [256];
    int               pl_due  [256];
    int               pl_head = 0, pl_tail = 0;

    function automatic logic [LINE_W-1:0] line_data(input logic [LINE_AW-1:0] l);
        logic [LINE_W-1:0] d;
        for (int w = 0; w < LINE_WORDS; w++)
            d[w*WORD_W +: WORD_W] = {32'(l) ^ 32'hC0DE_0000, 16'(w), 16'h5A5A};
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic idle();
        alloc_valid = '0; alloc_dest = '0; alloc_line = '0; alloc_word = '0;
        squash_mask = '0; ret_valid = 1'b0; ret_line = '0; ret_data = '0;
    endtask

    task automatic put(input int p, input int d, input int l, input int w);
        alloc_valid[p] = 1'b1;
        alloc_dest[p]  = DEST_W'(d);
        alloc_line[p]  = LINE_AW'(l);
        alloc_word[p]  = OFS_W'(w);
    endtask

    task automatic give(input int l);
        ret_valid = 1'b1;
        ret_line  = LINE_AW'(l);
        ret_data  = line_data(LINE_AW'(l));
    endtask

    // One cycle: inputs set by caller at the falling edge.
    task automatic step();
        logic [ALLOC_N-1:0]            ef;
        logic [DEST_N-1:0]             ew;
        logic [DEST_N-1:0][WORD_W-1:0] ed;
        #1;
        for (int p = 0; p < ALLOC_N; p++) begin
            bit fly = 1'b0;
            for (int d = 0; d < DEST_N; d++)
                if (m_busy[d] && m_line[d] == alloc_line[p] &&
                    !(ret_valid && ret_line == alloc_line[p])) fly = 1'b1;
            for (int q = 0; q < p; q++)
                if (alloc_valid[q] && alloc_line[q] == alloc_line[p]) fly = 1'b1;
            ef[p] = alloc_valid[p] && !fly;
        end
        chk(fetch_valid == ef, "R2 R3 fetch", 256'(fetch_valid), 256'(ef));
        for (int p = 0; p < ALLOC_N; p++)
            if (ef[p]) begin
                pl_line[pl_tail] = alloc_line[p];
                pl_due[pl_tail]  = cyc + LAT;
                pl_tail = (pl_tail + 1) % 256;
            end
        for (int d = 0; d < DEST_N; d++) begin
            bit h, s;
            bit [LINE_AW-1:0] nl;
            bit [OFS_W-1:0] nw;
            h = m_busy[d] && ret_valid && m_line[d] == ret_line;
            ew[d] = h && !m_cancel[d] && !squash_mask[d];
            ed[d] = ret_data[m_word[d]*WORD_W +: WORD_W];
            s = 1'b0; nl = '0; nw = '0;
            for (int p = 0; p < ALLOC_N; p++)
                if (alloc_valid[p] && alloc_dest[p] == DEST_W'(d)) begin
                    s = 1'b1; nl = alloc_line[p]; nw = alloc_word[p];
                end
            if (s) begin
                m_busy[d] = 1'b1; m_cancel[d] = 1'b0; m_line[d] = nl; m_word[d] = nw;
            end else if (h) begin
                m_busy[d] = 1'b0; m_cancel[d] = 1'b0;
            end else if (squash_mask[d] && m_busy[d]) begin
                m_cancel[d] = 1'b1;
            end
        end
        begin
            bit ev = |ew;
            logic [LINE_AW-1:0] el = ret_line;
            logic [LINE_W-1:0]  eld = ret_data;
            @(posedge clk);
            cyc++;
            @(negedge clk);
            chk(rf_we == ew, "R4 write enables", 256'(rf_we), 256'(ew));
            for (int d = 0; d < DEST_N; d++)
                if (ew[d] && rf_we[d])
                    chk(rf_wdata[d] == ed[d], "R4 word select", 256'(rf_wdata[d]), 256'(ed[d]));
            chk(fill_valid == ev, "R7 fill valid", 256'(fill_valid), 256'(ev));
            if (ev && fill_valid)
                chk(fill_line == el && fill_data == eld, "R7 fill payload",
                    256'(fill_line), 256'(el));
        end
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1995));
        idle();
        for (int d = 0; d < DEST_N; d++) begin
            m_busy[d] = 0; m_cancel[d] = 0; m_line[d] = 0; m_word[d] = 0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, then a stray return does nothing
        chk(rf_we == '0, "R1 reset we", 256'(rf_we), 0);
        chk(fill_valid == 1'b0, "R1 reset fill", 256'(fill_valid), 0);
        give(3); step();
        chk(rf_we == '0 && !fill_valid, "R1 empty return", 256'(rf_we), 0);

        // R2 R3: same line on both ports, then a pending duplicate
        put(0, 1, 7, 2); put(1, 3, 7, 0); step();
        put(0, 4, 7, 3); put(1, 6, 8, 1); step();
        give(7); step();
        chk(rf_we == 8'b0001_1010, "R4 all waiters in one cycle", 256'(rf_we), 256'(8'h1A));
        give(7); step();
        chk(rf_we == '0 && !fill_valid, "R5 cleared after return", 256'(rf_we), 0);
        give(8); step();

        // R6: squashed slot, and squash coinciding with return
        put(0, 5, 9, 1); step();
        squash_mask[5] = 1'b1; step();
        give(9); step();
        chk(!rf_we[5] && !fill_valid, "R6 cancelled slot silent", 256'(rf_we), 0);
        put(0, 2, 12, 0); step();
        squash_mask[2] = 1'b1; give(12); step();
        chk(!rf_we[2] && !fill_valid, "R6 same-cycle squash", 256'(rf_we), 0);

        // R8: port priority, alloc beats squash
        put(0, 2, 10, 0); put(1, 2, 11, 3); step();
        give(10); step();
        chk(rf_we[2] == 1'b0, "R8 lower port overwritten", 256'(rf_we), 0);
        give(11); step();
        chk(rf_we[2] == 1'b1, "R8 higher port wins", 256'(rf_we), 256'(8'h04));
        put(0, 4, 13, 2); squash_mask[4] = 1'b1; step();
        give(13); step();
        chk(rf_we[4] == 1'b1, "R8 alloc beats squash", 256'(rf_we), 256'(8'h10));

        // R3 exception: allocation while the same line returns
        put(0, 0, 30, 0); step();
        put(0, 1, 30, 1); give(30); step();
        give(30); step();
        chk(rf_we[1] == 1'b1, "R3 refetch on return cycle", 256'(rf_we), 256'(8'h02));

        // R9: all slots busy on distinct lines
        for (int d = 0; d < DEST_N; d += 2) begin
            put(0, d, 20 + d, d % 4); put(1, d + 1, 21 + d, (d + 1) % 4); step();
        end
        for (int d = 0; d < DEST_N; d++) begin
            give(20 + d); step();
            chk(rf_we == DEST_N'(1 << d), "R9 full capacity", 256'(rf_we), 256'(1 << d));
        end

        // Random traffic with a fixed-latency memory pipe
        pl_head = pl_tail;
        for (int i = 0; i < 3000; i++) begin
            if (pl_head != pl_tail && pl_due[pl_head] <= cyc) begin
                give(int'(pl_line[pl_head]));
                pl_head = (pl_head + 1) % 256;
            end
            if (((pl_tail - pl_head + 256) % 256) < 40)
                for (int p = 0; p < ALLOC_N; p++)
                    if ($urandom_range(0, 3) == 0)
                        put(p, $urandom_range(0, DEST_N - 1), 40 + $urandom_range(0, 5),
                            $urandom_range(0, LINE_WORDS - 1));
            if ($urandom_range(0, 15) == 0)
                squash_mask[$urandom_range(0, DEST_N - 1)] = 1'b1;
            step();
        end
        // drain
        while (pl_head != pl_tail) begin
            if (pl_due[pl_head] <= cyc) begin
                give(int'(pl_line[pl_head]));
                pl_head = (pl_head + 1) % 256;
            end
            step();
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule